// File: doc/BRIEF.md
# Shared RAM Bus Switch

This block holds a 1 KB byte-wide RAM that two masters take turns to use: a host bus with byte reads and writes, and a small 4-bit controller that presents an address, a 4-bit control word and two nibble output registers. A single direction line decides which side owns the RAM, in the way a pair of bus transceivers and address multiplexers would. The line is registered, so the owner seen by the RAM is the value the line had at the previous clock edge. Reset makes the host the owner.

When the controller owns the RAM, writes are level-sensitive. On every clock edge where both upper control bits are high, the byte built from the two nibble registers goes into the RAM at the controller address. No strobe is involved. If the control bits are already high when ownership moves to the controller, the write starts at once.

The host may still read while the controller owns the RAM. It gets the stored byte, but the access is reported as a conflict. A host write in that state is dropped and reported the same way. A controller read is valid only when it owns the RAM and control bit 2 is low. Any other controller read returns zero and raises an error pulse.

The host request channel uses valid/ready. `host_ready` is tied high, so a request is taken in the cycle its `host_valid` is high and there is never back-pressure. Read data returns on `host_rvalid`, which cannot be stalled. Control pins are plain levels.

Top module: `shram_bus_switch`

## Requirements
- R1: During and after reset `bus_owner` is 0, every RAM byte reads as 0, and `host_rvalid`, `host_conflict`, `mcu_rvalid` and `mcu_rd_err` are 0.
- R2: `bus_owner` equals the value `bus_dir` had at the previous clock edge (0 = host owns, 1 = controller owns). Every ownership decision in this block uses `bus_owner`.
- R3: A host write (`host_valid`=1, `host_we`=1) while `bus_owner`=0 stores `host_wdata` at the low 10 bits of `host_addr`. The upper address bits are ignored.
- R4: A host read (`host_valid`=1, `host_we`=0) raises `host_rvalid` one cycle later, with the stored byte on `host_rdata`.
- R5: A host write while `bus_owner`=1 leaves the RAM unchanged, and `host_conflict` is 1 in the following cycle only.
- R6: A host read while `bus_owner`=1 still returns the stored byte, and `host_conflict` is 1 in the following cycle.
- R7: On every clock edge where `bus_owner`=1 and `mcu_ctl[3]` and `mcu_ctl[2]` are both 1, the RAM byte at `mcu_addr` becomes {`mcu_r0`, `mcu_r1`}, with `mcu_r0` in bits 7:4. Holding the condition writes on every cycle it is held.
- R8: If `mcu_ctl[3:2]`=11 is already held when `bus_owner` rises to 1, the write takes place on the first edge with `bus_owner`=1. No change of address or data is needed.
- R9: A controller read (`mcu_rd`=1) with `bus_owner`=1 and `mcu_ctl[2]`=0 raises `mcu_rvalid` one cycle later, with the byte at `mcu_addr` on `mcu_rdata`.
- R10: A controller read under any other condition gives `mcu_rvalid`=1, `mcu_rdata`=0 and a one-cycle `mcu_rd_err`=1 in the following cycle.
- R11: A read in the same cycle as a write to the same address returns the byte as it was before that write.
- R12: `host_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_dir | input | 1 | Requested owner: 0 host, 1 controller |
| bus_owner | output | 1 | Registered owner in effect |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted (always 1) |
| host_we | input | 1 | Host request is a write |
| host_addr | input | 16 | Host address, low 10 bits used |
| host_wdata | input | 8 | Host write byte |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 8 | Host read byte |
| host_conflict | output | 1 | Host access made while the controller owned the RAM |
| mcu_addr | input | 10 | Controller RAM address |
| mcu_ctl | input | 4 | Controller control word, bits 3:2 select write/read |
| mcu_r0 | input | 4 | High nibble of the controller write byte |
| mcu_r1 | input | 4 | Low nibble of the controller write byte |
| mcu_rd | input | 1 | Controller read request |
| mcu_rvalid | output | 1 | Controller read result valid |
| mcu_rdata | output | 8 | Controller read byte, 0 when invalid |
| mcu_rd_err | output | 1 | Controller read was invalid |

## Verification
Each result has a fixed latency. Read data, `host_conflict` and `mcu_rd_err` come one edge after the request. A RAM write is visible to a read issued one cycle later. `bus_owner` follows `bus_dir` after one edge, so an ownership change needs one full cycle before it affects the next request. The bench drives inputs on falling edges and samples one falling edge later, after exactly one rising edge. Where a cycle straddles an ownership change, it waits the extra edge before it updates its expected RAM image.

// File: rtl/shram_pkg.sv
package shram_pkg;
  typedef enum logic {
    OWN_HOST = 1'b0,
    OWN_MCU  = 1'b1
  } owner_e;

  // control word bit positions used by the controller port
  localparam int CTL_WR_HI = 3;
  localparam int CTL_SEL   = 2;
endpackage

// File: rtl/shram_store.sv
module shram_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              own,
  input  logic              host_wen,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [DATA_W-1:0] host_wdat,
  input  logic              mcu_wen,
  input  logic [ADDR_W-1:0] mcu_waddr,
  input  logic [DATA_W-1:0] mcu_wdat,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wen;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdat;

  // owner-selected write path, like a transceiver pair
  always_comb begin
    if (own == shram_pkg::OWN_MCU) begin
      wen   = mcu_wen;
      waddr = mcu_waddr;
      wdat  = mcu_wdat;
    end else begin
      wen   = host_wen;
      waddr = host_waddr;
      wdat  = host_wdat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data_a <= '0;
      rd_data_b <= '0;
    end else begin
      rd_data_a <= mem[rd_addr_a];
      rd_data_b <= mem[rd_addr_b];
      if (wen) mem[waddr] <= wdat;
    end
  end

  // R2: the two port decoders never both claim the RAM
  a_r2_single_writer: assert property (@(posedge clk) disable iff (rst)
    !(host_wen && mcu_wen));
endmodule

// File: rtl/shram_host_port.sv
module shram_host_port #(
  parameter int ADDR_W  = 10,
  parameter int HOST_AW = 16,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               own,
  input  logic               host_valid,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic               wen,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  wdat,
  output logic               host_rvalid,
  output logic               host_conflict
);
  logic rd_req, wr_req;

  assign wr_req = host_valid && host_we;
  assign rd_req = host_valid && !host_we;
  assign addr   = host_addr[ADDR_W-1:0];
  assign wdat   = host_wdata;
  assign wen    = wr_req && (own == shram_pkg::OWN_HOST);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid   <= 1'b0;
      host_conflict <= 1'b0;
    end else begin
      host_rvalid   <= rd_req;
      host_conflict <= host_valid && (own == shram_pkg::OWN_MCU);
    end
  end

  // R5/R6: a conflict is only ever reported for an access under controller ownership
  a_r6_conflict_needs_mcu: assert property (@(posedge clk) disable iff (rst)
    host_conflict |-> $past(own) == shram_pkg::OWN_MCU);
  // R4: read data valid follows a read request
  a_r4_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(host_valid && !host_we));
endmodule

// File: rtl/shram_mcu_port.sv
module shram_mcu_port #(
  parameter int ADDR_W = 10,
  parameter int NIB_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               own,
  input  logic [ADDR_W-1:0]  mcu_addr,
  input  logic [3:0]         mcu_ctl,
  input  logic [NIB_W-1:0]   mcu_r0,
  input  logic [NIB_W-1:0]   mcu_r1,
  input  logic               mcu_rd,
  input  logic [2*NIB_W-1:0] ram_rdata,
  output logic               wen,
  output logic [ADDR_W-1:0]  addr,
  output logic [2*NIB_W-1:0] wdat,
  output logic               mcu_rvalid,
  output logic [2*NIB_W-1:0] mcu_rdata,
  output logic               mcu_rd_err
);
  import shram_pkg::*;

  logic rd_ok, rd_ok_q;

  assign addr  = mcu_addr;
  assign wdat  = {mcu_r0, mcu_r1};
  // level-sensitive write: evaluated every cycle against the current owner
  assign wen   = (own == OWN_MCU) && mcu_ctl[CTL_WR_HI] && mcu_ctl[CTL_SEL];
  assign rd_ok = (own == OWN_MCU) && !mcu_ctl[CTL_SEL];

  always_ff @(posedge clk) begin
    if (rst) begin
      mcu_rvalid <= 1'b0;
      mcu_rd_err <= 1'b0;
      rd_ok_q    <= 1'b0;
    end else begin
      mcu_rvalid <= mcu_rd;
      mcu_rd_err <= mcu_rd && !rd_ok;
      rd_ok_q    <= mcu_rd && rd_ok;
    end
  end

  assign mcu_rdata = rd_ok_q ? ram_rdata : '0;

  // R10: an invalid read never leaks RAM data
  a_r10_err_data_zero: assert property (@(posedge clk) disable iff (rst)
    mcu_rd_err |-> (mcu_rdata == '0 && mcu_rvalid));
endmodule

// File: rtl/shram_bus_switch.sv
module shram_bus_switch #(
  parameter int ADDR_W  = 10,
  parameter int HOST_AW = 16,
  parameter int NIB_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_dir,
  output logic               bus_owner,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [2*NIB_W-1:0] host_wdata,
  output logic               host_rvalid,
  output logic [2*NIB_W-1:0] host_rdata,
  output logic               host_conflict,
  input  logic [ADDR_W-1:0]  mcu_addr,
  input  logic [3:0]         mcu_ctl,
  input  logic [NIB_W-1:0]   mcu_r0,
  input  logic [NIB_W-1:0]   mcu_r1,
  input  logic               mcu_rd,
  output logic               mcu_rvalid,
  output logic [2*NIB_W-1:0] mcu_rdata,
  output logic               mcu_rd_err
);
  localparam int DATA_W = 2 * NIB_W;

  logic              own_q;
  logic              h_wen, m_wen;
  logic [ADDR_W-1:0] h_addr, m_addr;
  logic [DATA_W-1:0] h_wdat, m_wdat, rd_b;

  always_ff @(posedge clk) begin
    if (rst) own_q <= shram_pkg::OWN_HOST;
    else     own_q <= bus_dir;
  end

  assign bus_owner  = own_q;
  assign host_ready = 1'b1;

  shram_host_port #(.ADDR_W(ADDR_W), .HOST_AW(HOST_AW), .DATA_W(DATA_W)) u_host (
    .clk(clk), .rst(rst), .own(own_q),
    .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .wen(h_wen), .addr(h_addr), .wdat(h_wdat),
    .host_rvalid(host_rvalid), .host_conflict(host_conflict)
  );

  shram_mcu_port #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_mcu (
    .clk(clk), .rst(rst), .own(own_q),
    .mcu_addr(mcu_addr), .mcu_ctl(mcu_ctl), .mcu_r0(mcu_r0), .mcu_r1(mcu_r1),
    .mcu_rd(mcu_rd), .ram_rdata(rd_b), .wen(m_wen), .addr(m_addr), .wdat(m_wdat),
    .mcu_rvalid(mcu_rvalid), .mcu_rdata(mcu_rdata), .mcu_rd_err(mcu_rd_err)
  );

  shram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .own(own_q),
    .host_wen(h_wen), .host_waddr(h_addr), .host_wdat(h_wdat),
    .mcu_wen(m_wen), .mcu_waddr(m_addr), .mcu_wdat(m_wdat),
    .rd_addr_a(h_addr), .rd_addr_b(m_addr),
    .rd_data_a(host_rdata), .rd_data_b(rd_b)
  );

  // R1: the first cycle out of reset gives the RAM to the host
  a_r1_reset_owner: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bus_owner == shram_pkg::OWN_HOST);
  // R2: owner tracks the direction line one edge late
  a_r2_owner_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> bus_owner == $past(bus_dir));
  // R10: error pulse only for a read request
  a_r10_err_after_read: assert property (@(posedge clk) disable iff (rst)
    mcu_rd_err |-> $past(mcu_rd));
endmodule

// File: tb/sim_shram_bus_switch.sv
`timescale 1ns/1ps
module sim_shram_bus_switch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_dir = 1'b0;
  logic        bus_owner;
  logic        host_valid = 1'b0, host_ready, host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_rvalid, host_conflict;
  logic [7:0]  host_rdata;
  logic [9:0]  mcu_addr = '0;
  logic [3:0]  mcu_ctl = '0, mcu_r0 = '0, mcu_r1 = '0;
  logic        mcu_rd = 1'b0, mcu_rvalid, mcu_rd_err;
  logic [7:0]  mcu_rdata;

  logic [7:0]  exp_mem [1024];
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  shram_bus_switch u0 (
    .clk(clk), .rst(rst), .bus_dir(bus_dir), .bus_owner(bus_owner),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .host_conflict(host_conflict),
    .mcu_addr(mcu_addr), .mcu_ctl(mcu_ctl), .mcu_r0(mcu_r0), .mcu_r1(mcu_r1),
    .mcu_rd(mcu_rd), .mcu_rvalid(mcu_rvalid), .mcu_rdata(mcu_rdata),
    .mcu_rd_err(mcu_rd_err)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // one host access; outputs sampled one rising edge later
  task automatic host_op(input bit we, input logic [15:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output bit rv, output bit cf);
    @(negedge clk);
    host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    rd = host_rdata; rv = host_rvalid; cf = host_conflict;
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic mcu_read(input logic [9:0] a, input logic [3:0] ctl,
                          output logic [7:0] rd, output bit rv, output bit er);
    @(negedge clk);
    mcu_rd = 1'b1; mcu_addr = a; mcu_ctl = ctl;
    @(negedge clk);
    rd = mcu_rdata; rv = mcu_rvalid; er = mcu_rd_err;
    mcu_rd = 1'b0;
  endtask

  task automatic set_dir(input bit d);
    @(negedge clk);
    bus_dir = d;
    @(negedge clk);
    check("R2 owner", bus_owner, d);
  endtask

  initial begin
    logic [7:0] rd;
    bit rv, cf, er;
    for (int i = 0; i < 1024; i++) exp_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    // R1 state during reset
    @(negedge clk);
    check("R1 owner in reset", bus_owner, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 owner", bus_owner, 0);
    check("R1 rvalid", host_rvalid, 0);
    check("R1 conflict", host_conflict, 0);
    check("R1 mcu_rvalid", mcu_rvalid, 0);
    check("R1 rd_err", mcu_rd_err, 0);
    check("R12 ready", host_ready, 1);
    // R1 RAM cleared: full sweep
    for (int a = 0; a < 1024; a++) begin
      host_op(1'b0, 16'(a), 8'h00, rd, rv, cf);
      check("R1 cleared byte", rd, 0);
    end
    // R3 write sweep with junk upper address bits
    for (int a = 0; a < 1024; a++) begin
      logic [7:0] d;
      d = 8'((a * 37 + 11) & 255);
      host_op(1'b1, 16'(a | ((a % 7) << 10)), d, rd, rv, cf);
      exp_mem[a] = d;
      check("R3 no conflict on write", cf, 0);
    end
    // R4 read sweep
    for (int a = 0; a < 1024; a++) begin
      host_op(1'b0, 16'(a), 8'h00, rd, rv, cf);
      check("R4 rvalid", rv, 1);
      check("R3/R4 data", rd, exp_mem[a]);
    end
    // give RAM to controller
    set_dir(1'b1);
    // R5 dropped write + one-cycle conflict
    host_op(1'b1, 16'h0005, 8'hAA, rd, rv, cf);
    check("R5 conflict", cf, 1);
    @(negedge clk);
    check("R5 conflict pulse ends", host_conflict, 0);
    // R6 read under controller ownership
    host_op(1'b0, 16'h0005, 8'h00, rd, rv, cf);
    check("R5/R6 data unchanged", rd, exp_mem[5]);
    check("R6 conflict", cf, 1);
    check("R12 ready", host_ready, 1);
    // R7 continuous level write over 64 addresses
    @(negedge clk);
    mcu_ctl = 4'b1100;
    for (int k = 0; k < 64; k++) begin
      mcu_addr = 10'(100 + k); mcu_r0 = 4'(k); mcu_r1 = ~4'(k);
      @(negedge clk);
      exp_mem[100 + k] = {4'(k), ~4'(k)};
    end
    mcu_ctl = 4'b0000;
    for (int k = 0; k < 64; k++) begin
      mcu_read(10'(100 + k), 4'b0000, rd, rv, er);
      check("R7/R9 mcu data", rd, exp_mem[100 + k]);
      check("R9 rvalid", rv, 1);
      check("R9 no err", er, 0);
    end
    // R11 host read same cycle as controller write to same address
    @(negedge clk);
    mcu_addr = 10'd300; mcu_r0 = 4'hF; mcu_r1 = 4'h0; mcu_ctl = 4'b1100;
    host_valid = 1'b1; host_we = 1'b0; host_addr = 16'd300;
    @(negedge clk);
    check("R11 old data", host_rdata, exp_mem[300]);
    check("R6 conflict", host_conflict, 1);
    host_valid = 1'b0; mcu_ctl = 4'b0000;
    exp_mem[300] = 8'hF0;
    mcu_read(10'd300, 4'b0000, rd, rv, er);
    check("R7 written byte", rd, 8'hF0);
    // R10 invalid reads
    mcu_read(10'd300, 4'b0100, rd, rv, er);
    check("R10 err ctl bit2", er, 1);
    check("R10 zero data", rd, 0);
    check("R10 rvalid", rv, 1);
    @(negedge clk);
    check("R10 err pulse ends", mcu_rd_err, 0);
    set_dir(1'b0);
    mcu_read(10'd300, 4'b0000, rd, rv, er);
    check("R10 err host owner", er, 1);
    check("R10 zero data host owner", rd, 0);
    // R7: controller write condition has no effect while host owns
    @(negedge clk);
    mcu_addr = 10'd400; mcu_r0 = 4'h3; mcu_r1 = 4'hC; mcu_ctl = 4'b1100;
    repeat (2) @(negedge clk);
    host_op(1'b0, 16'd400, 8'h00, rd, rv, cf);
    check("R7 no write without owner", rd, exp_mem[400]);
    // R8 ownership change alone starts the write
    set_dir(1'b1);
    @(negedge clk);
    exp_mem[400] = 8'h3C;
    mcu_ctl = 4'b0000;
    set_dir(1'b0);
    host_op(1'b0, 16'd400, 8'h00, rd, rv, cf);
    check("R8 write on owner change", rd, 8'h3C);
    check("R4 no conflict as owner", cf, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule